// File: doc/BRIEF.md
# I2C Byte-DMA Address Tracker

This block holds the working memory pointer and the byte budget of the byte-wide DMA engine inside an I2C controller. Software loads a buffer address and a buffer length through a simple register write port. The serial shifter raises a one-cycle strobe for each byte moved to or from memory. Each strobe steps the pointer forward by one byte and takes one from the remaining count. The pointer is 64 bits wide so that buffers above the 4 GiB line can be reached. Software writes reach only its low 32 bits. The high half changes only through the carry of the byte increment, or through reset.

Two register views are supported. The legacy view has a single word-aligned address register and a length register that is loaded directly. The newer view has separate transmit, receive and target-receive address registers. Each of these loads the remaining length from its own buffer-length register plus one. In the newer view the block also keeps a running count of received bytes. A target-receive start clears that count and arms the pointer from the target registers. A configuration without DMA support returns all ones on the legacy address register and ignores the legacy loads.

Top module: `i2c_dma_addr_track`

## Requirements
- R1: Reset (rstN low) clears memAddr, remLen and rxCount to zero, so done reads 1.
- R2: With newMode=0 and DMA supported, a write to register 0 sets memAddr[31:0] to the data ANDed with 0x3FFFFFFC. remLen is not changed.
- R3: With newMode=1, a write to register 2 (transmit address) sets memAddr[31:0] to the data. remLen becomes the stored transmit length (register 4) plus one.
- R4: With newMode=1, a write to register 3 (receive address) sets memAddr[31:0] to the data. remLen becomes the stored receive length (register 5) plus one.
- R5: A byte strobe while remLen is nonzero adds one to the full 64-bit memAddr, carrying into bits [63:32], and subtracts one from remLen.
- R6: done is high exactly when remLen is zero. Byte strobes are then ignored: memAddr, remLen and rxCount hold.
- R7: No register write changes memAddr[63:32].
- R8: A tgtRxStart pulse sets rxCount to 0, memAddr[31:0] to register 6 and remLen to register 7 plus one. It takes priority over an address write in the same cycle.
- R9: With newMode=1, each accepted byte strobe with byteIsRx=1 adds one to rxCount. Transmit bytes and legacy-mode bytes leave it unchanged.
- R10: Reading register 0 (legacy address) or register 8 (current address) returns memAddr[31:0]. Register 9 returns memAddr[63:32], register 10 returns remLen and register 11 returns rxCount. Without DMA support, register 0 reads all ones and legacy address writes are ignored.
- R11: With newMode=0 and DMA supported, a write to register 1 loads remLen directly with the data.
- R12: Legacy address and length writes (registers 0 and 1) are ignored when newMode=1. Transmit and receive address writes (registers 2 and 3) are ignored when newMode=0.
- R13: When an address or length load and a byte strobe fall in the same cycle, the load takes effect and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| newMode | input | 1 | 1 selects the newer register view, 0 the legacy view |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register write select |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 4 | Register read select |
| regRdData | output | 32 | Combinational read data |
| byteStrobe | input | 1 | One byte moved by the shifter this cycle |
| byteIsRx | input | 1 | The strobed byte was received (written to memory) |
| tgtRxStart | input | 1 | Start of a target-mode receive |
| memAddr | output | 64 | Current memory request address |
| remLen | output | LEN_W+1 | Remaining byte count |
| done | output | 1 | Remaining count is zero |
| rxCount | output | LEN_W+1 | Received-byte count |

## Verification
Every piece of internal state can be seen on the ports within one cycle. A wrong pointer shows on memAddr on the clock after the faulty load or increment. A wrong length shows on remLen and done at the same time. A lost carry shows only when a buffer crosses a 4 GiB line, so a buffer is placed on that edge. Priority errors between a load, a target start and a strobe in the same cycle give a wrong pointer one clock later, so those collisions are driven on purpose. The configuration without DMA is exercised next to the default one to catch a wrong choice of legacy read value.

// File: rtl/i2c_dma_trk_pkg.sv
package i2c_dma_trk_pkg;

  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] REG_LEG_ADDR = 4'd0;
  localparam logic [REG_AW-1:0] REG_LEG_LEN  = 4'd1;
  localparam logic [REG_AW-1:0] REG_TX_ADDR  = 4'd2;
  localparam logic [REG_AW-1:0] REG_RX_ADDR  = 4'd3;
  localparam logic [REG_AW-1:0] REG_TX_LEN   = 4'd4;
  localparam logic [REG_AW-1:0] REG_RX_LEN   = 4'd5;
  localparam logic [REG_AW-1:0] REG_TGT_ADDR = 4'd6;
  localparam logic [REG_AW-1:0] REG_TGT_LEN  = 4'd7;
  localparam logic [REG_AW-1:0] REG_CUR_ADDR = 4'd8;
  localparam logic [REG_AW-1:0] REG_ADDR_HI  = 4'd9;
  localparam logic [REG_AW-1:0] REG_REM_LEN  = 4'd10;
  localparam logic [REG_AW-1:0] REG_RX_COUNT = 4'd11;

  typedef enum logic [2:0] {
    LD_NONE,
    LD_LEGACY,
    LD_TX,
    LD_RX,
    LD_TGT
  } loadSel_e;

  typedef struct packed {
    loadSel_e addrLoad;
    logic     legLenLoad;
    logic     wrTxAddr;
    logic     wrRxAddr;
    logic     wrTxLen;
    logic     wrRxLen;
    logic     wrTgtAddr;
    logic     wrTgtLen;
    logic     advance;
    logic     countRx;
    logic     clearCount;
  } dmaStrobe_t;

endpackage

// File: rtl/i2c_dma_trk_ctrl.sv
module i2c_dma_trk_ctrl
  import i2c_dma_trk_pkg::*;
#(
  parameter bit DMA_SUPPORTED = 1'b1
) (
  input  logic              newMode,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              byteStrobe,
  input  logic              byteIsRx,
  input  logic              tgtRxStart,
  input  logic              lenZero,
  output dmaStrobe_t        stb
);

  logic hitLegAddr, hitLegLen, hitTxAddr, hitRxAddr;
  logic anyLoad;

  assign hitLegAddr = regWrEn && (regAddr == REG_LEG_ADDR) && !newMode && DMA_SUPPORTED;
  assign hitLegLen  = regWrEn && (regAddr == REG_LEG_LEN) && !newMode && DMA_SUPPORTED;
  assign hitTxAddr  = regWrEn && (regAddr == REG_TX_ADDR) && newMode;
  assign hitRxAddr  = regWrEn && (regAddr == REG_RX_ADDR) && newMode;

  always_comb begin
    stb.wrTxAddr   = hitTxAddr;
    stb.wrRxAddr   = hitRxAddr;
    stb.wrTxLen    = regWrEn && (regAddr == REG_TX_LEN);
    stb.wrRxLen    = regWrEn && (regAddr == REG_RX_LEN);
    stb.wrTgtAddr  = regWrEn && (regAddr == REG_TGT_ADDR);
    stb.wrTgtLen   = regWrEn && (regAddr == REG_TGT_LEN);
    stb.clearCount = tgtRxStart;

    if (tgtRxStart)      stb.addrLoad = LD_TGT;
    else if (hitLegAddr) stb.addrLoad = LD_LEGACY;
    else if (hitTxAddr)  stb.addrLoad = LD_TX;
    else if (hitRxAddr)  stb.addrLoad = LD_RX;
    else                 stb.addrLoad = LD_NONE;

    stb.legLenLoad = hitLegLen && !tgtRxStart;
    anyLoad        = (stb.addrLoad != LD_NONE) || stb.legLenLoad;
    stb.advance    = byteStrobe && !lenZero && !anyLoad;
    stb.countRx    = stb.advance && byteIsRx && newMode;
  end

endmodule

// File: rtl/i2c_dma_trk_dp.sv
module i2c_dma_trk_dp
  import i2c_dma_trk_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int DATA_W        = 32,
  parameter int LEN_W         = 16,
  parameter bit DMA_SUPPORTED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        stb,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [REG_AW-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W:0]    remLen,
  output logic [LEN_W:0]    rxCount,
  output logic              lenZero
);

  localparam int CNT_W = LEN_W + 1;
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam logic [DATA_W-1:0] LEG_MASK = {2'b00, {(DATA_W-4){1'b1}}, 2'b00};
  localparam logic [CNT_W-1:0]  ONE_C    = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);

  logic [DATA_W-1:0] txAddrQ, rxAddrQ, tgtAddrQ;
  logic [LEN_W-1:0]  txLenQ, rxLenQ, tgtLenQ;
  logic [DATA_W-1:0] lowLoadVal;
  logic [DATA_W-1:0] legacyView;
  logic [HI_W-1:0]   hiPart;

  assign hiPart  = curAddr[ADDR_W-1:DATA_W];
  assign lenZero = (remLen == '0);

  // programmed buffer registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txAddrQ  <= '0;
      rxAddrQ  <= '0;
      tgtAddrQ <= '0;
      txLenQ   <= '0;
      rxLenQ   <= '0;
      tgtLenQ  <= '0;
    end else begin
      if (stb.wrTxAddr)  txAddrQ  <= regWrData;
      if (stb.wrRxAddr)  rxAddrQ  <= regWrData;
      if (stb.wrTgtAddr) tgtAddrQ <= regWrData;
      if (stb.wrTxLen)   txLenQ   <= regWrData[LEN_W-1:0];
      if (stb.wrRxLen)   rxLenQ   <= regWrData[LEN_W-1:0];
      if (stb.wrTgtLen)  tgtLenQ  <= regWrData[LEN_W-1:0];
    end
  end

  always_comb begin
    case (stb.addrLoad)
      LD_LEGACY: lowLoadVal = regWrData & LEG_MASK;
      LD_TX,
      LD_RX:     lowLoadVal = regWrData;
      LD_TGT:    lowLoadVal = tgtAddrQ;
      default:   lowLoadVal = curAddr[DATA_W-1:0];
    endcase
  end

  // 64-bit pointer: loads touch only the low half
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (stb.addrLoad != LD_NONE) begin
      curAddr <= {hiPart, lowLoadVal};
    end else if (stb.advance) begin
      curAddr <= curAddr + ONE_A;
    end
  end

  // remaining byte budget
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remLen <= '0;
    end else begin
      case (stb.addrLoad)
        LD_TX:  remLen <= CNT_W'(txLenQ) + ONE_C;
        LD_RX:  remLen <= CNT_W'(rxLenQ) + ONE_C;
        LD_TGT: remLen <= CNT_W'(tgtLenQ) + ONE_C;
        default: begin
          if (stb.legLenLoad)   remLen <= regWrData[CNT_W-1:0];
          else if (stb.advance) remLen <= remLen - ONE_C;
        end
      endcase
    end
  end

  // received-byte counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCount <= '0;
    end else if (stb.clearCount) begin
      rxCount <= '0;
    end else if (stb.countRx) begin
      rxCount <= rxCount + ONE_C;
    end
  end

  generate
    if (DMA_SUPPORTED) begin : g_dmaView
      assign legacyView = curAddr[DATA_W-1:0];
    end else begin : g_noDmaView
      assign legacyView = '1;
    end
  endgenerate

  always_comb begin
    case (regRdAddr)
      REG_LEG_ADDR: regRdData = legacyView;
      REG_TX_ADDR:  regRdData = txAddrQ;
      REG_RX_ADDR:  regRdData = rxAddrQ;
      REG_TX_LEN:   regRdData = DATA_W'(txLenQ);
      REG_RX_LEN:   regRdData = DATA_W'(rxLenQ);
      REG_TGT_ADDR: regRdData = tgtAddrQ;
      REG_TGT_LEN:  regRdData = DATA_W'(tgtLenQ);
      REG_CUR_ADDR: regRdData = curAddr[DATA_W-1:0];
      REG_ADDR_HI:  regRdData = DATA_W'(hiPart);
      REG_REM_LEN:  regRdData = DATA_W'(remLen);
      REG_RX_COUNT: regRdData = DATA_W'(rxCount);
      default:      regRdData = '0;
    endcase
  end

endmodule

// File: rtl/i2c_dma_addr_track.sv
module i2c_dma_addr_track
  import i2c_dma_trk_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int DATA_W        = 32,
  parameter int LEN_W         = 16,
  parameter bit DMA_SUPPORTED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              newMode,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [3:0]        regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  input  logic              byteStrobe,
  input  logic              byteIsRx,
  input  logic              tgtRxStart,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LEN_W:0]    remLen,
  output logic              done,
  output logic [LEN_W:0]    rxCount
);

  dmaStrobe_t stb;
  logic       lenZero;

  i2c_dma_trk_ctrl #(
    .DMA_SUPPORTED(DMA_SUPPORTED)
  ) u_ctrl (
    .newMode   (newMode),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .byteStrobe(byteStrobe),
    .byteIsRx  (byteIsRx),
    .tgtRxStart(tgtRxStart),
    .lenZero   (lenZero),
    .stb       (stb)
  );

  i2c_dma_trk_dp #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .LEN_W        (LEN_W),
    .DMA_SUPPORTED(DMA_SUPPORTED)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regWrData(regWrData),
    .regRdAddr(regRdAddr),
    .regRdData(regRdData),
    .curAddr  (memAddr),
    .remLen   (remLen),
    .rxCount  (rxCount),
    .lenZero  (lenZero)
  );

  assign done = lenZero;

endmodule

// File: rtl/i2c_dma_addr_track_chk.sv
module i2c_dma_addr_track_chk #(
  parameter int ADDR_W        = 64,
  parameter int DATA_W        = 32,
  parameter int LEN_W         = 16,
  parameter bit DMA_SUPPORTED = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              newMode,
  input logic              regWrEn,
  input logic [3:0]        regAddr,
  input logic              byteStrobe,
  input logic              byteIsRx,
  input logic              tgtRxStart,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LEN_W:0]    remLen,
  input logic              done,
  input logic [LEN_W:0]    rxCount
);

  localparam logic [LEN_W:0]    ONE_L = (LEN_W+1)'(1);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  logic quietStrobe;
  assign quietStrobe = byteStrobe && !regWrEn && !tgtRxStart;

  p_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    (quietStrobe && !done) |=> (memAddr == $past(memAddr) + ONE_A) && (remLen == $past(remLen) - ONE_L));

  p_hold_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (quietStrobe && done) |=> $stable(memAddr) && $stable(remLen) && $stable(rxCount));

  p_high_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !byteStrobe && !tgtRxStart) |=> (memAddr[ADDR_W-1:DATA_W] == $past(memAddr[ADDR_W-1:DATA_W])));

  p_tgt_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    tgtRxStart |=> (rxCount == '0));

  p_legacy_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    (DMA_SUPPORTED && regWrEn && regAddr == 4'd0 && !newMode && !tgtRxStart)
      |=> (memAddr[1:0] == 2'b00) && (memAddr[DATA_W-1:DATA_W-2] == 2'b00));

  p_rx_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (quietStrobe && byteIsRx && newMode && !done) |=> (rxCount == $past(rxCount) + ONE_L));

endmodule

bind i2c_dma_addr_track i2c_dma_addr_track_chk #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .LEN_W        (LEN_W),
  .DMA_SUPPORTED(DMA_SUPPORTED)
) u_chk (.*);

// File: tb/i2c_dma_addr_track_bench.sv
module i2c_dma_addr_track_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  typedef struct packed {
    logic        mode;
    logic        wr;
    logic [3:0]  ra;
    logic [31:0] wd;
    logic        stb;
    logic        rx;
    logic [7:0]  req;
    logic [31:0] expLow;
    logic [16:0] expLen;
    logic [16:0] expCnt;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 4'd4, 32'd3,          1'b0, 1'b0, 8'd3,  32'h0,        17'd0, 17'd0}, // R3 stage tx len
    '{1'b1, 1'b1, 4'd2, 32'h1000,       1'b0, 1'b0, 8'd3,  32'h1000,     17'd4, 17'd0}, // R3 tx load
    '{1'b1, 1'b0, 4'd0, 32'h0,          1'b1, 1'b0, 8'd5,  32'h1001,     17'd3, 17'd0}, // R5 tx byte
    '{1'b1, 1'b0, 4'd0, 32'h0,          1'b1, 1'b0, 8'd9,  32'h1002,     17'd2, 17'd0}, // R9 tx not counted
    '{1'b1, 1'b1, 4'd5, 32'd1,          1'b0, 1'b0, 8'd4,  32'h1002,     17'd2, 17'd0}, // R4 stage rx len
    '{1'b1, 1'b1, 4'd3, 32'h2000,       1'b0, 1'b0, 8'd4,  32'h2000,     17'd2, 17'd0}, // R4 rx load
    '{1'b1, 1'b0, 4'd0, 32'h0,          1'b1, 1'b1, 8'd9,  32'h2001,     17'd1, 17'd1}, // R9 rx count
    '{1'b1, 1'b0, 4'd0, 32'h0,          1'b1, 1'b1, 8'd9,  32'h2002,     17'd0, 17'd2}, // R9
    '{1'b1, 1'b0, 4'd0, 32'h0,          1'b1, 1'b1, 8'd6,  32'h2002,     17'd0, 17'd2}, // R6 ignored at zero
    '{1'b0, 1'b1, 4'd1, 32'd5,          1'b0, 1'b0, 8'd11, 32'h2002,     17'd5, 17'd2}, // R11 legacy length
    '{1'b0, 1'b1, 4'd0, 32'hFFFF_FFFF,  1'b0, 1'b0, 8'd2,  32'h3FFF_FFFC, 17'd5, 17'd2}, // R2 mask
    '{1'b0, 1'b0, 4'd0, 32'h0,          1'b1, 1'b1, 8'd9,  32'h3FFF_FFFD, 17'd4, 17'd2}, // R9 legacy no count
    '{1'b0, 1'b1, 4'd2, 32'h5555,       1'b0, 1'b0, 8'd12, 32'h3FFF_FFFD, 17'd4, 17'd2}, // R12 tx in legacy
    '{1'b1, 1'b1, 4'd0, 32'h100,        1'b0, 1'b0, 8'd12, 32'h3FFF_FFFD, 17'd4, 17'd2}, // R12 legacy addr in new
    '{1'b1, 1'b1, 4'd1, 32'd9,          1'b0, 1'b0, 8'd12, 32'h3FFF_FFFD, 17'd4, 17'd2}  // R12 legacy len in new
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        newMode = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [3:0]  regRdAddr = '0;
  logic        byteStrobe = 1'b0;
  logic        byteIsRx = 1'b0;
  logic        tgtRxStart = 1'b0;
  logic [31:0] regRdData, ndRdData;
  logic [63:0] memAddr, ndMemAddr;
  logic [LEN_W:0] remLen, ndRemLen, rxCount, ndRxCount;
  logic        done, ndDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dma_addr_track u_i2c_dma_addr_track (
    .clk(clk), .rstN(rstN), .newMode(newMode), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .byteStrobe(byteStrobe), .byteIsRx(byteIsRx), .tgtRxStart(tgtRxStart),
    .memAddr(memAddr), .remLen(remLen), .done(done), .rxCount(rxCount)
  );

  i2c_dma_addr_track #(.DMA_SUPPORTED(1'b0)) u_noDma (
    .clk(clk), .rstN(rstN), .newMode(newMode), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(ndRdData),
    .byteStrobe(byteStrobe), .byteIsRx(byteIsRx), .tgtRxStart(tgtRxStart),
    .memAddr(ndMemAddr), .remLen(ndRemLen), .done(ndDone), .rxCount(ndRxCount)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
    byteStrobe = 1'b0;
    byteIsRx = 1'b0;
    tgtRxStart = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWrEn = 1'b1;
    regAddr = a;
    regWrData = d;
    step();
  endtask

  task automatic rd(input logic [3:0] a);
    regRdAddr = a;
    #1;
  endtask

  task automatic strobe(input logic rx);
    byteStrobe = 1'b1;
    byteIsRx = rx;
    step();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 memAddr", memAddr, 64'h0);
    check("R1 remLen", 64'(remLen), 64'h0);
    check("R1 rxCount/done", {rxCount, done}, {17'd0, 1'b1});
    rstN = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      newMode = VECS[i].mode;
      regWrEn = VECS[i].wr;
      regAddr = VECS[i].ra;
      regWrData = VECS[i].wd;
      byteStrobe = VECS[i].stb;
      byteIsRx = VECS[i].rx;
      step();
      checks++;
      if ({memAddr[31:0], remLen, rxCount} !== {VECS[i].expLow, VECS[i].expLen, VECS[i].expCnt}) begin
        errors++;
        $display("FAIL R%0d row %0d: actual %h/%0d/%0d expected %h/%0d/%0d", VECS[i].req, i,
                 memAddr[31:0], remLen, rxCount, VECS[i].expLow, VECS[i].expLen, VECS[i].expCnt);
      end
    end

    // R5 carry across the 4 GiB line, R6 stop at zero
    newMode = 1'b1;
    wr(4'd4, 32'd0);
    wr(4'd2, 32'hFFFF_FFFF);
    check("R3 tx load len0", {memAddr, 47'(remLen)}, {64'h0000_0000_FFFF_FFFF, 47'd1});
    strobe(1'b0);
    check("R5 carry", memAddr, 64'h1_0000_0000);
    check("R6 done", 64'(done), 64'd1);
    strobe(1'b1);
    check("R6 hold", {memAddr, 47'(remLen)}, {64'h1_0000_0000, 47'd0});

    // R7 high half kept, R4 rx length
    wr(4'd3, 32'h10);
    check("R7 high kept", memAddr, 64'h1_0000_0010);
    check("R4 rx len", 64'(remLen), 64'd2);
    rd(4'd9);  check("R10 read hi", 64'(regRdData), 64'd1);
    rd(4'd8);  check("R10 read cur", 64'(regRdData), 64'h10);
    rd(4'd0);  check("R10 read legacy", 64'(regRdData), 64'h10);

    // R8 target start beats same-cycle address write
    wr(4'd6, 32'h400);
    wr(4'd7, 32'd2);
    tgtRxStart = 1'b1;
    regWrEn = 1'b1;
    regAddr = 4'd2;
    regWrData = 32'h777;
    step();
    check("R8 addr", memAddr, 64'h1_0000_0400);
    check("R8 len/count", {47'(remLen), 17'(rxCount)}, {47'd3, 17'd0});
    strobe(1'b1);
    rd(4'd11); check("R9 read count", 64'(regRdData), 64'd1);
    rd(4'd10); check("R10 read remLen", 64'(regRdData), 64'd2);

    // R13 load wins over strobe
    regWrEn = 1'b1;
    regAddr = 4'd2;
    regWrData = 32'h50;
    byteStrobe = 1'b1;
    step();
    check("R13 load wins", {memAddr, 47'(remLen)}, {64'h1_0000_0050, 47'd1});

    // R1 reset mid-run, then R10 no-DMA variant
    rstN = 1'b0;
    #1;
    check("R1 async clear", {memAddr, 17'(remLen), 17'(rxCount)}, {64'h0, 17'd0, 17'd0});
    step();
    rstN = 1'b1;
    newMode = 1'b0;
    wr(4'd0, 32'h100);
    check("R2 legacy load", memAddr, 64'h100);
    check("R10 no-DMA write ignored", ndMemAddr, 64'h0);
    rd(4'd0);
    check("R10 legacy read", 64'(regRdData), 64'h100);
    check("R10 no-DMA reads ones", 64'(ndRdData), 64'hFFFF_FFFF);

    finish();
  end

endmodule